// File: doc/BRIEF.md
# Dual-Mode Indexed Palette Lookup

This block turns a pixel colour index into a 15-bit RGB colour. It holds a 512-entry palette store. The lower 256 entries serve the background layer and the upper 256 serve the object layer. Each request names its layer, a pixel format flag (8 bits or 4 bits per pixel), the pixel value, and a 4-bit bank number that is used only in the 4-bit format. In the 8-bit format the pixel value selects any entry in the layer's half. In the 4-bit format the bank number selects one group of sixteen entries, and the pixel's low nibble selects an entry within that group. A pixel value of zero always means transparent.

The result appears one clock after the request, together with a transparency flag. A separate write port loads palette words. Each stored word has the layout `X_BBBBB_GGGGG_RRRRR`. The top bit carries no meaning and never reaches the output.

Top module: `pal_lookup`

## Requirements
- R1: While reset is held, and on the first sample after it, `outValid`, `outColor` and `outTransparent` are all zero.
- R2: `outValid` is high exactly one clock after a clock edge at which `reqValid` was high, and low otherwise.
- R3: With `reqMode4`=0, the entry read is at address `reqLayer*256 + reqPixel`, so background and object tables are separate.
- R4: With `reqMode4`=1, the entry read is at address `reqLayer*256 + reqBank*16 + reqPixel[3:0]`. `reqPixel[7:4]` has no effect.
- R5: A request whose pixel field is zero gives `outTransparent`=1 and `outColor`=0. The pixel field is all of `reqPixel` in 8-bit mode and `reqPixel[3:0]` in 4-bit mode. Any other pixel field gives `outTransparent`=0.
- R6: `outColor` equals bits 14:0 of the stored word. Bit 15 of a written word never appears on the output.
- R7: A clock edge with `wrEn`=1 stores `wrData` at entry `wrAddr`, where 0–255 is background and 256–511 is object.
- R8: When a write and a lookup of the same entry share a clock edge, the lookup returns the contents from before the write. Later lookups return the new word.
- R9: While `outValid` is low, `outColor` and `outTransparent` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request present |
| reqLayer | input | 1 | 0 = background table, 1 = object table |
| reqMode4 | input | 1 | 1 = 4 bits per pixel, 0 = 8 bits per pixel |
| reqPixel | input | 8 | Pixel colour index |
| reqBank | input | 4 | Bank number for the 4-bit format |
| wrEn | input | 1 | Palette write strobe |
| wrAddr | input | 9 | Palette entry to write |
| wrData | input | 16 | Colour word; bit 15 is ignored |
| outValid | output | 1 | Result present |
| outColor | output | 15 | RGB colour, 5 bits per channel, red in the low bits |
| outTransparent | output | 1 | Pixel is transparent |

## Verification
The embedded assertions check several properties on every cycle: the one-clock alignment of `outValid` with a request, the forced zero colour on transparent results, the quiet outputs between results, and that a zero pixel field always produces a transparent flag. Address formation in both formats, the separation of the two layer tables, the masking of bit 15, and the old-data result of a colliding write can only be shown by the bench. It preloads distinct words into every entry and compares each output against its own model of the palette.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Strobes passed from the request decoder to the storage datapath
  typedef struct packed {
    logic rdEn;      // a lookup is issued this cycle
    logic transp;    // the pixel field of this lookup is zero
  } palStrobe_t;

endpackage

// File: rtl/pal_ctrl.sv
module pal_ctrl #(
  parameter int IDX_W  = 8,
  parameter int SUB_W  = 4,
  localparam int BANK_W = IDX_W - SUB_W,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic                  reqValid,
  input  logic                  reqLayer,
  input  logic                  reqMode4,
  input  logic [IDX_W-1:0]      reqPixel,
  input  logic [BANK_W-1:0]     reqBank,
  output pal_pkg::palStrobe_t   strobe,
  output logic [ADDR_W-1:0]     rdAddr
);

  logic [IDX_W-1:0] flatIdx;
  logic [IDX_W-1:0] bankIdx;
  logic             flatZero;
  logic             subZero;

  // 8-bit format: the whole pixel value picks the entry in the layer half
  assign flatIdx  = reqPixel;
  assign flatZero = (reqPixel == '0);

  // 4-bit format: bank number on top, low pixel nibble below
  assign bankIdx  = {reqBank, reqPixel[SUB_W-1:0]};
  assign subZero  = (reqPixel[SUB_W-1:0] == '0);

  always_comb begin
    strobe.rdEn = reqValid;
    if (reqMode4) begin
      rdAddr        = {reqLayer, bankIdx};
      strobe.transp = subZero;
    end else begin
      rdAddr        = {reqLayer, flatIdx};
      strobe.transp = flatZero;
    end
  end

endmodule

// File: rtl/pal_datapath.sv
module pal_datapath #(
  parameter int IDX_W   = 8,
  parameter int WORD_W  = 16,
  parameter int COLOR_W = 15,
  localparam int ADDR_W  = IDX_W + 1,
  localparam int ENTRIES = 1 << ADDR_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  pal_pkg::palStrobe_t strobe,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [WORD_W-1:0]   wrData,
  output logic                outValid,
  output logic [COLOR_W-1:0]  outColor,
  output logic                outTransparent
);

  // Only the colour bits are kept; the spare top bits are dropped on write
  logic [COLOR_W-1:0] palMem [ENTRIES];
  logic [WORD_W-COLOR_W-1:0] unusedSpare;

  assign unusedSpare = wrData[WORD_W-1:COLOR_W];

  always_ff @(posedge clk) begin
    if (wrEn) begin
      palMem[wrAddr] <= wrData[COLOR_W-1:0];
    end
  end

  // The read samples the array at the same edge as any write, so a
  // colliding lookup sees the previous contents
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid       <= 1'b0;
      outColor       <= '0;
      outTransparent <= 1'b0;
    end else if (strobe.rdEn) begin
      outValid       <= 1'b1;
      outTransparent <= strobe.transp;
      outColor       <= strobe.transp ? '0 : palMem[rdAddr];
    end else begin
      outValid       <= 1'b0;
      outColor       <= '0;
      outTransparent <= 1'b0;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> outValid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> !outValid);

  assert_transp_blank_R5: assert property (@(posedge clk) disable iff (!rstN)
    outTransparent |-> (outColor == '0));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outColor == '0 && !outTransparent));

endmodule

// File: rtl/pal_lookup.sv
module pal_lookup #(
  parameter int IDX_W   = 8,
  parameter int SUB_W   = 4,
  parameter int WORD_W  = 16,
  parameter int COLOR_W = 15,
  localparam int BANK_W = IDX_W - SUB_W,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqLayer,
  input  logic               reqMode4,
  input  logic [IDX_W-1:0]   reqPixel,
  input  logic [BANK_W-1:0]  reqBank,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [WORD_W-1:0]  wrData,
  output logic               outValid,
  output logic [COLOR_W-1:0] outColor,
  output logic               outTransparent
);

  pal_pkg::palStrobe_t strobe;
  logic [ADDR_W-1:0]   rdAddr;

  pal_ctrl #(.IDX_W(IDX_W), .SUB_W(SUB_W)) ctrl_i (
    .reqValid (reqValid),
    .reqLayer (reqLayer),
    .reqMode4 (reqMode4),
    .reqPixel (reqPixel),
    .reqBank  (reqBank),
    .strobe   (strobe),
    .rdAddr   (rdAddr)
  );

  pal_datapath #(.IDX_W(IDX_W), .WORD_W(WORD_W), .COLOR_W(COLOR_W)) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .rdAddr         (rdAddr),
    .wrEn           (wrEn),
    .wrAddr         (wrAddr),
    .wrData         (wrData),
    .outValid       (outValid),
    .outColor       (outColor),
    .outTransparent (outTransparent)
  );

  // A zero pixel field at the ports must come back flagged transparent
  assert_zero_pixel_transp_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ((reqMode4 && reqPixel[SUB_W-1:0] == '0) ||
                  (!reqMode4 && reqPixel == '0))) |=> outTransparent);

endmodule

// File: tb/pal_lookup_tb.sv
module pal_lookup_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqLayer, reqMode4;
  logic [7:0]  reqPixel;
  logic [3:0]  reqBank;
  logic        wrEn;
  logic [8:0]  wrAddr;
  logic [15:0] wrData;
  logic        outValid;
  logic [14:0] outColor;
  logic        outTransparent;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [15:0] model [512];

  always #10 clk = ~clk;

  pal_lookup dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLayer(reqLayer),
    .reqMode4(reqMode4), .reqPixel(reqPixel), .reqBank(reqBank),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .outValid(outValid),
    .outColor(outColor), .outTransparent(outTransparent)
  );

  task automatic check(string tag, logic v, logic [14:0] c, logic t);
    compared++;
    if (outValid !== v || outColor !== c || outTransparent !== t) begin
      mismatched++;
      $display("FAIL %s: got valid=%0b color=%h transp=%0b, expected valid=%0b color=%h transp=%0b",
               tag, outValid, outColor, outTransparent, v, c, t);
    end
  endtask

  // Drive one cycle of stimulus (called at a falling edge) and compare the
  // result at the next falling edge against the behavioural palette model
  task automatic step(string tag, bit v, bit layer, bit m4, logic [7:0] pix,
                      logic [3:0] bank, bit we, logic [8:0] wa, logic [15:0] wd);
    int idx;
    logic        expV, expT;
    logic [14:0] expC;
    reqValid = v; reqLayer = layer; reqMode4 = m4; reqPixel = pix; reqBank = bank;
    wrEn = we; wrAddr = wa; wrData = wd;
    expV = v; expT = 1'b0; expC = '0;
    if (v) begin
      if (m4) begin
        idx  = layer * 256 + bank * 16 + pix % 16;
        expT = (pix % 16 == 0);
      end else begin
        idx  = layer * 256 + pix;
        expT = (pix == 0);
      end
      if (!expT) expC = model[idx][14:0];
    end
    if (we) model[wa] = wd;
    @(negedge clk);
    check(tag, expV, expC, expT);
  endtask

  function automatic logic [15:0] pattern(int a);
    return 16'((a * 16'h9E37 + 16'h1234) ^ (a << 7)) | ((a % 3 == 0) ? 16'h8000 : 16'h0);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got running, expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 0; reqLayer = 0; reqMode4 = 0; reqPixel = 0;
    reqBank = 0; wrEn = 0; wrAddr = 0; wrData = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, '0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", 1'b0, '0, 1'b0);

    // R7/R9: fill every entry while idle; outputs stay quiet
    for (int a = 0; a < 512; a++) step("R7 R9 fill", 0, 0, 0, 0, 0, 1, 9'(a), pattern(a));

    // R3/R6: 8-bit lookups on both layers, including entries with bit 15 set
    for (int p = 0; p < 256; p += 7) begin
      step("R3 R6 flat bg", 1, 0, 0, 8'(p), 4'(p), 0, 0, 0);
      step("R3 R6 flat obj", 1, 1, 0, 8'(255 - p), 4'(p), 0, 0, 0);
    end
    step("R3 flat top", 1, 1, 0, 8'hFF, 0, 0, 0, 0);

    // R4: 4-bit lookups, upper pixel nibble filled with noise
    for (int b = 0; b < 16; b++) begin
      step("R4 bank bg", 1, 0, 1, 8'((b * 37) & 8'hF0 | ((b + 3) % 16 == 0 ? 1 : (b + 3) % 16)), 4'(b), 0, 0, 0);
      step("R4 bank obj", 1, 1, 1, 8'(8'hA0 | 4'hF), 4'(b), 0, 0, 0);
    end

    // R5: transparency in both formats
    step("R5 flat zero bg", 1, 0, 0, 8'h00, 4'h5, 0, 0, 0);
    step("R5 flat zero obj", 1, 1, 0, 8'h00, 4'hF, 0, 0, 0);
    step("R5 bank zero nibble", 1, 0, 1, 8'hF0, 4'h9, 0, 0, 0);
    step("R5 bank zero obj", 1, 1, 1, 8'h00, 4'h0, 0, 0, 0);
    step("R5 flat 0x10 opaque", 1, 0, 0, 8'h10, 4'h0, 0, 0, 0);

    // R9: gaps between requests
    step("R9 gap", 0, 1, 1, 8'h33, 4'h3, 0, 0, 0);
    step("R2 after gap", 1, 0, 0, 8'h21, 0, 0, 0, 0);
    step("R9 gap2", 0, 0, 0, 8'h21, 0, 0, 0, 0);

    // R8: colliding write and lookup, then the new word is visible
    step("R8 collide flat", 1, 0, 0, 8'h42, 0, 1, 9'h042, 16'hFFFF);
    step("R8 new flat", 1, 0, 0, 8'h42, 0, 0, 0, 0);
    step("R8 collide bank", 1, 1, 1, 8'hE7, 4'hC, 1, 9'h1C7, 16'h7ABC);
    step("R8 new bank", 1, 1, 1, 8'h07, 4'hC, 0, 0, 0);
    step("R7 write during lookup", 1, 0, 0, 8'h01, 0, 1, 9'h101, 16'h0F0F);
    step("R7 read written obj", 1, 1, 0, 8'h01, 0, 0, 0, 0);
    step("R9 final idle", 0, 0, 0, 0, 0, 0, 0, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule